// File: doc/BRIEF.md
# Synchronous SRAM Read Output Path with Deselect Sequencing

This block is the read-data output stage of a synchronous SRAM. Each clock it takes a command code from the command decoder and, in the cycle after capture, the word read from the array. From these it drives the data output bus and a set of per-lane drive enables that control the tri-state pads. The array contents, the address logic and the analog drive strength are outside this block.

Two static mode inputs shape the timing. The first selects registered output, which adds one cycle of latency, or flow-through output. The second selects how deep a deselect is pipelined. With single-cycle deselect, the drivers turn off as soon as a non-read command reaches the first stage. With dual-cycle deselect, the drivers stay on for one more cycle, so a deselect takes as long to act as a read. An active-low output enable gates the drivers without waiting for a clock edge. A read issued while that enable is high is a dummy read: it moves through the pipeline but drives nothing, so the next cycle can be a write with no deselect between them.

A sleep input puts the block to sleep once it has been high at two consecutive clock edges. While asleep, the drivers are off and commands are ignored. After sleep is released there is a recovery window of a set number of cycles. In that window a write is refused and flagged, while reads and deselects are accepted.

Top module: `sramrd_out_path`

## Requirements
- R1: While reset is high, and in the first cycle after it, all drive enables and `err_o` are low and `dq_o` is zero.
- R2: With `ft_i` = 1 (registered output), a read captured at clock edge k drives the `rdata_i` word present just before edge k+1. That word appears during the cycle after edge k+1.
- R3: With `ft_i` = 0 (flow-through), a read captured at edge k drives `rdata_i` straight through during the cycle after edge k.
- R4: With `scd_i` = 1 and registered output, the drivers are off in any cycle whose first stage holds a command other than a read. This holds even when the second stage holds a read.
- R5: With `scd_i` = 0 and registered output, a read followed by a deselect keeps driving the read word for its full cycle. The drivers are off one cycle later.
- R6: With flow-through output, a read followed by a deselect drives for one extra cycle only when `scd_i` = 0. During that cycle the last read word is held on the bus. With `scd_i` = 1 there is no extra cycle.
- R7: All lanes of `dq_oe_o` always carry the same value. Every lane is off in any cycle whose first stage holds a write, in every mode.
- R8: `oe_n_i` high turns every lane off in the same cycle, with no clock edge needed. `oe_n_i` low enables only what the pipeline marks active. A read issued with `oe_n_i` high still advances the pipeline, so a write that follows it causes no drive.
- R9: The command code on `cmd_i` is 2'b00 deselect, 2'b01 read and 2'b10 write. The code 2'b11 is treated as a deselect.
- R10: When `zz_i` is high at two consecutive edges, the block is asleep from the second edge. While asleep, every lane is off and commands are captured as deselects. A `zz_i` pulse high at a single edge has no effect.
- R11: When `zz_i` is first sampled low while asleep, a recovery window of RECOV_CYC cycles begins. A write presented in that window is dropped and treated as a deselect, and `err_o` is high in the following cycle. Reads in the window are accepted.
- R12: After the recovery window ends, writes are accepted again and `err_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ft_i | input | 1 | 1 = registered output, 0 = flow-through |
| scd_i | input | 1 | 1 = single-cycle deselect, 0 = dual-cycle deselect |
| oe_n_i | input | 1 | Output enable, active low, acts without a clock edge |
| zz_i | input | 1 | Sleep request, active high |
| cmd_i | input | 2 | Command code from the decoder |
| rdata_i | input | DW | Array read word, valid in the cycle after a read is captured |
| dq_o | output | DW | Output data, zero when not driven |
| dq_oe_o | output | LANES | Per-lane drive enable |
| err_o | output | 1 | Write refused during sleep recovery (one-cycle pulse) |

## Verification
A stale or wrong stage register shows at the ports within one or two cycles. The drive enable opens or closes a cycle too early or too late around a read followed by a deselect or a write, or the bus carries the word of the wrong read. A wrong sleep state or recovery counter shows as lanes driving while asleep, as a missing or extra `err_o` pulse in the cycle after a write near the end of the recovery window, or as a dropped write that lets the drivers stay on. The bench steps a behavioural model alongside the design and compares bus, enables and error flag every cycle, in all four mode combinations.

// File: rtl/sramrd_pkg.sv
package sramrd_pkg;

    typedef enum logic [1:0] {
        CMD_DESEL = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_SPARE = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        SLP_AWAKE,
        SLP_PEND,
        SLP_ASLEEP,
        SLP_RECOVER
    } slp_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } stage_t;

    function automatic stage_t classify(input cmd_e c);
        stage_t s;
        s.rd = (c == CMD_READ);
        s.wr = (c == CMD_WRITE);
        return s;
    endfunction

endpackage

// File: rtl/sramrd_sleep_gate.sv
module sramrd_sleep_gate
    import sramrd_pkg::*;
#(
    parameter int RECOV_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       zz_i,
    input  logic [1:0] cmd_i,
    output stage_t     acc_o,
    output logic       asleep_o,
    output logic       err_o
);
    localparam int CW = (RECOV_CYC < 2) ? 1 : $clog2(RECOV_CYC + 1);

    slp_e          state_q;
    logic [CW-1:0] cnt_q;
    stage_t        dec;
    logic          bad_wr;

    always_comb begin
        dec    = classify(cmd_e'(cmd_i));
        acc_o  = dec;
        bad_wr = 1'b0;
        if (state_q == SLP_ASLEEP) begin
            acc_o = '0;
        end else if (state_q == SLP_RECOVER && dec.wr) begin
            acc_o  = '0;
            bad_wr = 1'b1;
        end
    end

    assign asleep_o = (state_q == SLP_ASLEEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLP_AWAKE;
            cnt_q   <= '0;
            err_o   <= 1'b0;
        end else begin
            err_o <= bad_wr;
            case (state_q)
                SLP_AWAKE: if (zz_i) state_q <= SLP_PEND;
                SLP_PEND:  state_q <= zz_i ? SLP_ASLEEP : SLP_AWAKE;
                SLP_ASLEEP: begin
                    if (!zz_i) begin
                        state_q <= SLP_RECOVER;
                        cnt_q   <= CW'(RECOV_CYC);
                    end
                end
                SLP_RECOVER: begin
                    if (zz_i)                    state_q <= SLP_PEND;
                    else if (cnt_q == CW'(1))    state_q <= SLP_AWAKE;
                    else                         cnt_q   <= cnt_q - CW'(1);
                end
                default: state_q <= SLP_AWAKE;
            endcase
        end
    end

    // R10
    sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SLP_PEND && zz_i) |=> asleep_o);

    // R11
    err_window_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(state_q == SLP_RECOVER));

endmodule

// File: rtl/sramrd_stage_pipe.sv
module sramrd_stage_pipe
    import sramrd_pkg::*;
#(
    parameter int DW = 72
) (
    input  logic          clk,
    input  logic          rst,
    input  stage_t        acc_i,
    input  logic [DW-1:0] rdata_i,
    output stage_t        s1_o,
    output stage_t        s2_o,
    output logic [DW-1:0] hold_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_o   <= '0;
            s2_o   <= '0;
            hold_o <= '0;
        end else begin
            if (s1_o.rd) hold_o <= rdata_i;
            s2_o <= s1_o;
            s1_o <= acc_i;
        end
    end

    // R2
    hold_capture_chk: assert property (@(posedge clk) disable iff (rst)
        $past(s1_o.rd) |-> hold_o == $past(rdata_i));

    // R9
    stage_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({s1_o.rd, s1_o.wr}));

endmodule

// File: rtl/sramrd_drive.sv
module sramrd_drive
    import sramrd_pkg::*;
#(
    parameter int DW    = 72,
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ft_i,
    input  logic             scd_i,
    input  logic             oe_n_i,
    input  logic             asleep_i,
    input  stage_t           s1_i,
    input  stage_t           s2_i,
    input  logic [DW-1:0]    rdata_i,
    input  logic [DW-1:0]    hold_i,
    output logic [DW-1:0]    dq_o,
    output logic [LANES-1:0] dq_oe_o
);
    localparam int LW = DW / LANES;

    logic          reg_act;
    logic          ft_act;
    logic          en;
    logic [DW-1:0] src;

    always_comb begin
        reg_act = s2_i.rd && (scd_i ? s1_i.rd : !s1_i.wr);
        ft_act  = s1_i.rd || (!scd_i && s2_i.rd && !s1_i.rd && !s1_i.wr);
        en      = (ft_i ? reg_act : ft_act) && !s1_i.wr && !oe_n_i && !asleep_i;
        src     = (!ft_i && s1_i.rd) ? rdata_i : hold_i;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dq_oe_o[g]          = en;
        assign dq_o[g*LW +: LW]    = en ? src[g*LW +: LW] : '0;
    end

    // R8
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n_i |-> dq_oe_o == '0);

    // R7
    lane_match_chk: assert property (@(posedge clk) disable iff (rst)
        (dq_oe_o == '0) || (dq_oe_o == {LANES{1'b1}}));

    // R7
    wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        s1_i.wr |-> dq_oe_o == '0);

    // R10
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        asleep_i |-> dq_oe_o == '0);

endmodule

// File: rtl/sramrd_out_path.sv
module sramrd_out_path
    import sramrd_pkg::*;
#(
    parameter int DW        = 72,
    parameter int LANES     = 8,
    parameter int RECOV_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ft_i,
    input  logic             scd_i,
    input  logic             oe_n_i,
    input  logic             zz_i,
    input  logic [1:0]       cmd_i,
    input  logic [DW-1:0]    rdata_i,
    output logic [DW-1:0]    dq_o,
    output logic [LANES-1:0] dq_oe_o,
    output logic             err_o
);
    stage_t        acc;
    stage_t        s1;
    stage_t        s2;
    logic          asleep;
    logic [DW-1:0] hold;

    sramrd_sleep_gate #(.RECOV_CYC(RECOV_CYC)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .zz_i     (zz_i),
        .cmd_i    (cmd_i),
        .acc_o    (acc),
        .asleep_o (asleep),
        .err_o    (err_o)
    );

    sramrd_stage_pipe #(.DW(DW)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .acc_i   (acc),
        .rdata_i (rdata_i),
        .s1_o    (s1),
        .s2_o    (s2),
        .hold_o  (hold)
    );

    sramrd_drive #(.DW(DW), .LANES(LANES)) u_drive (
        .clk      (clk),
        .rst      (rst),
        .ft_i     (ft_i),
        .scd_i    (scd_i),
        .oe_n_i   (oe_n_i),
        .asleep_i (asleep),
        .s1_i     (s1),
        .s2_i     (s2),
        .rdata_i  (rdata_i),
        .hold_i   (hold),
        .dq_o     (dq_o),
        .dq_oe_o  (dq_oe_o)
    );

endmodule

// File: tb/tb_sramrd_out_path.sv
module tb_sramrd_out_path;
    localparam int DW        = 72;
    localparam int LANES     = 8;
    localparam int RECOV_CYC = 4;
    localparam int PERIOD    = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ft_i = 1'b1, scd_i = 1'b1, oe_n_i = 1'b0, zz_i = 1'b0;
    logic [1:0]       cmd_i = 2'b00;
    logic [DW-1:0]    rdata_i = '0;
    logic [DW-1:0]    dq_o;
    logic [LANES-1:0] dq_oe_o;
    logic             err_o;

    int total = 0, bad = 0, seed = 1;
    bit done = 0;

    // behavioural model state
    int            q[$];
    logic [DW-1:0] m_hold;
    int            m_slp;   // 0 awake 1 pending 2 asleep 3 recovering
    int            m_rcnt;
    bit            m_err;

    always #(PERIOD/2) clk = ~clk;

    sramrd_out_path #(.DW(DW), .LANES(LANES), .RECOV_CYC(RECOV_CYC)) dut (
        .clk(clk), .rst(rst), .ft_i(ft_i), .scd_i(scd_i), .oe_n_i(oe_n_i),
        .zz_i(zz_i), .cmd_i(cmd_i), .rdata_i(rdata_i), .dq_o(dq_o),
        .dq_oe_o(dq_oe_o), .err_o(err_o)
    );

    function automatic logic [DW-1:0] pattern(input int s);
        logic [DW-1:0] v;
        for (int i = 0; i < DW/8; i++) v[8*i +: 8] = 8'(s * 37 + i * 5 + 1);
        return v;
    endfunction

    task automatic model_reset();
        q = {0, 0};
        m_hold = '0; m_slp = 0; m_rcnt = 0; m_err = 0;
    endtask

    task automatic compare(input string tag);
        bit en;
        logic [DW-1:0] data, exp_dq;
        int s1, s2;
        s1 = q[0]; s2 = q[1];
        if (ft_i) en = (s2 == 1) && (scd_i ? (s1 == 1) : (s1 != 2));
        else      en = (s1 == 1) || (!scd_i && s2 == 1 && s1 == 0);
        if (oe_n_i || m_slp == 2) en = 0;
        data   = (!ft_i && s1 == 1) ? rdata_i : m_hold;
        exp_dq = en ? data : '0;
        total += 3;
        if (dq_oe_o !== {LANES{en}}) begin
            bad++; $display("FAIL %s oe actual=%b expected=%b", tag, dq_oe_o, {LANES{en}});
        end
        if (dq_o !== exp_dq) begin
            bad++; $display("FAIL %s dq actual=%h expected=%h", tag, dq_o, exp_dq);
        end
        if (err_o !== m_err) begin
            bad++; $display("FAIL %s err actual=%b expected=%b", tag, err_o, m_err);
        end
    endtask

    task automatic model_step(input int c, input bit z);
        int g;
        bit nerr;
        nerr = 0;
        g = (c == 3) ? 0 : c;
        if (m_slp == 2) g = 0;
        else if (m_slp == 3 && g == 2) begin g = 0; nerr = 1; end
        if (q[0] == 1) m_hold = rdata_i;
        q.push_front(g);
        void'(q.pop_back());
        m_err = nerr;
        case (m_slp)
            0: if (z) m_slp = 1;
            1: m_slp = z ? 2 : 0;
            2: if (!z) begin m_slp = 3; m_rcnt = RECOV_CYC; end
            default: begin
                if (z) m_slp = 1;
                else if (m_rcnt == 1) m_slp = 0;
                else m_rcnt--;
            end
        endcase
    endtask

    task automatic cyc(input logic [1:0] c, input bit z, input bit oe, input string tag);
        @(negedge clk);
        cmd_i = c; zz_i = z; oe_n_i = oe;
        seed++;
        rdata_i = pattern(seed);
        #1;
        compare(tag);
        @(posedge clk);
        model_step(int'(c), z);
    endtask

    task automatic flush(input string tag);
        for (int i = 0; i < 3; i++) cyc(2'b00, 0, 0, tag);
    endtask

    task automatic set_mode(input bit ft, input bit scd);
        @(negedge clk);
        ft_i = ft; scd_i = scd;
    endtask

    // R1-style reset check and the scenario sequence
    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        compare("R1 in reset");
        @(negedge clk);
        rst = 1'b0;
        #1;
        compare("R1 after reset");
        @(posedge clk);
        model_step(0, 0);

        // registered output, single-cycle deselect
        set_mode(1, 1);
        cyc(2'b01, 0, 0, "R2 read a");
        cyc(2'b01, 0, 0, "R2 read b");
        cyc(2'b01, 0, 0, "R2 read c");
        cyc(2'b00, 0, 0, "R4 scd deselect");
        cyc(2'b00, 0, 0, "R4 scd off");
        cyc(2'b01, 0, 0, "R4 read");
        cyc(2'b10, 0, 0, "R7 write after read");
        cyc(2'b00, 0, 0, "R7 write stage");
        flush("R4 flush");

        // registered output, dual-cycle deselect
        set_mode(1, 0);
        cyc(2'b01, 0, 0, "R5 read");
        cyc(2'b00, 0, 0, "R5 deselect");
        cyc(2'b00, 0, 0, "R5 held cycle");
        cyc(2'b00, 0, 0, "R5 off");
        cyc(2'b01, 0, 0, "R7 read");
        cyc(2'b10, 0, 0, "R7 write");
        cyc(2'b00, 0, 0, "R7 dcd write stage");
        cyc(2'b01, 0, 0, "R9 read");
        cyc(2'b11, 0, 0, "R9 spare code");
        cyc(2'b00, 0, 0, "R9 spare as deselect");
        flush("R5 flush");

        // flow-through, single-cycle deselect
        set_mode(0, 1);
        cyc(2'b01, 0, 0, "R3 read");
        cyc(2'b01, 0, 0, "R3 read next");
        cyc(2'b00, 0, 0, "R6 scd deselect");
        cyc(2'b00, 0, 0, "R6 scd off");
        cyc(2'b01, 0, 0, "R9 ft read");
        cyc(2'b11, 0, 0, "R9 ft spare");
        cyc(2'b00, 0, 0, "R9 ft spare off");
        flush("R3 flush");

        // flow-through, dual-cycle deselect
        set_mode(0, 0);
        cyc(2'b01, 0, 0, "R6 dcd read");
        cyc(2'b00, 0, 0, "R6 dcd deselect");
        cyc(2'b00, 0, 0, "R6 dcd extension");
        cyc(2'b00, 0, 0, "R6 dcd off");
        cyc(2'b01, 0, 0, "R7 ft read");
        cyc(2'b10, 0, 0, "R7 ft write");
        cyc(2'b00, 0, 0, "R7 ft write stage");
        flush("R6 flush");

        // output enable and dummy read, registered dual-cycle deselect
        set_mode(1, 0);
        cyc(2'b01, 0, 0, "R8 read");
        cyc(2'b01, 0, 1, "R8 oe high");
        cyc(2'b01, 0, 0, "R8 oe low");
        cyc(2'b00, 0, 1, "R8 oe high again");
        cyc(2'b00, 0, 0, "R8 settle");
        cyc(2'b01, 0, 1, "R8 dummy read");
        cyc(2'b10, 0, 1, "R8 dummy then write");
        cyc(2'b00, 0, 0, "R8 write stage oe low");
        cyc(2'b00, 0, 0, "R8 after write");
        flush("R8 flush");

        // sleep: single-edge pulse is ignored
        cyc(2'b01, 1, 0, "R10 pulse");
        cyc(2'b01, 0, 0, "R10 pulse read");
        cyc(2'b01, 0, 0, "R10 still awake");
        cyc(2'b00, 0, 0, "R10 drain");
        // sleep entry with reads in flight
        cyc(2'b01, 1, 0, "R10 zz edge one");
        cyc(2'b01, 1, 0, "R10 zz edge two");
        cyc(2'b01, 1, 0, "R10 asleep read ignored");
        cyc(2'b10, 1, 0, "R10 asleep write ignored");
        cyc(2'b01, 1, 0, "R10 asleep");
        // release and recovery window
        cyc(2'b01, 0, 0, "R11 release edge");
        cyc(2'b01, 0, 0, "R11 recovery read");
        cyc(2'b10, 0, 0, "R11 write refused");
        cyc(2'b00, 0, 0, "R11 err pulse");
        cyc(2'b10, 0, 0, "R11 last window write");
        cyc(2'b00, 0, 0, "R11 err again");
        cyc(2'b01, 0, 0, "R12 read");
        cyc(2'b10, 0, 0, "R12 write accepted");
        cyc(2'b00, 0, 0, "R12 no err");
        cyc(2'b00, 0, 0, "R12 quiet");
        flush("R12 flush");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 50000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule